// File: doc/BRIEF.md
# Asynchronous Word Bit-Clock Generator

This block sits behind an FSK demodulator and turns the demodulated asynchronous character stream into a simple synchronous peripheral interface. The raw line is passed straight out, so it still works as an ordinary asynchronous serial signal. Alongside it the block emits a gated bit clock and a per-word ready strobe, so that a plain shift register or a small controller can take in each character without doing its own bit timing.

Each character is one start bit, eight data bits sent LSB first, and one stop bit, at a fixed baud rate. The block times the bits with a 16x oversampling tick derived from the system clock. It confirms a start bit at its centre. It then raises one bit-clock edge at the centre of each data bit and none during the start or stop bit. A ready pulse marks each well-framed word. A mode input enables this output mode only while it is low.

Top module: `awc_bitclk_gen`

## Requirements
- R1: `data_o` always equals `rx_i`, in either mode and in every state.
- R2: Each framed word yields exactly 8 rising edges on `bclk_o`, and never a ninth.
- R3: Each rising edge of `bclk_o` lies at the centre of a data bit cell. Sampling `data_o` on those edges, LSB first, reproduces the transmitted byte.
- R4: `bclk_o` never rises during the start bit or the stop bit.
- R5: A word whose stop bit samples high gives one `dr_o` pulse. It rises at the centre of the stop bit while the line is high, and it never overlaps a bit-clock pulse.
- R6: The `dr_o` pulse is exactly as wide as one `bclk_o` high time, and a following start bit that arrives at once is not lost.
- R7: A falling edge is accepted as a start only if the line is still low at the start-bit centre. A shorter low glitch produces no bit clocks and no ready pulse.
- R8: If the stop bit samples low, `dr_o` stays low. The block waits for the line to go high and then receives the next word normally.
- R9: While `mode_i` is high, `bclk_o` and `dr_o` are held low and no word is framed.
- R10: Timing comes from a tick every CLK_HZ/(BAUD*16) clocks. A `bclk_o` high time lasts 8 ticks, which is half a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Demodulated serial line, idle high |
| mode_i | input | 1 | Low enables bit-clock output mode; high holds outputs low |
| data_o | output | 1 | Pass-through of the serial line |
| bclk_o | output | 1 | Gated bit clock, 8 pulses per word |
| dr_o | output | 1 | Data-ready pulse per well-framed word |

## Verification
The bound checker watches several rules on every cycle: the outputs stay quiet in the disabled mode, ready and bit clock never overlap, exactly eight bit-clock edges precede each ready pulse, every pulse has the fixed width, and the line is high when ready rises. Some behaviour only the bench scenarios can show. These are the byte recovered from mid-cell sampling, the absence of edges in the start and stop cells, the rejection of short glitches, recovery after a low stop bit, back-to-back words with no idle gap, and pass-through of the raw line in both modes.

// File: rtl/awc_pkg.sv
package awc_pkg;
  localparam int OSR       = 16;
  localparam int WORD_BITS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_BREAK
  } frm_state_e;
endpackage

// File: rtl/awc_tick_gen.sv
module awc_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/awc_sync.sv
module awc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/awc_framer.sv
module awc_framer
  import awc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic mode_i,
  output logic bclk_o,
  output logic dr_o,
  output logic idle_o
);
  localparam int PW = $clog2(OSR);
  localparam int CNTW = $clog2(WORD_BITS + 1);
  localparam logic [PW-1:0]   PH_LAST = PW'(OSR - 1);
  localparam logic [PW-1:0]   PH_HALF = PW'(OSR / 2 - 1);
  localparam logic [CNTW-1:0] CNT_END = CNTW'(WORD_BITS);

  frm_state_e      state_q;
  logic [PW-1:0]   phase_q;
  logic [PW-1:0]   dr_tmr_q;
  logic [CNTW-1:0] cnt_q;
  logic            rx_prev_q, bclk_q, dr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= '0;
      dr_tmr_q  <= '0;
      cnt_q     <= '0;
      rx_prev_q <= 1'b1;
      bclk_q    <= 1'b0;
      dr_q      <= 1'b0;
    end else if (mode_i) begin
      state_q  <= ST_IDLE;
      phase_q  <= '0;
      dr_tmr_q <= '0;
      cnt_q    <= '0;
      bclk_q   <= 1'b0;
      dr_q     <= 1'b0;
      if (tick_i) rx_prev_q <= rx_i;
    end else if (tick_i) begin
      rx_prev_q <= rx_i;
      // ready pulse timed apart from the FSM so a new start is never missed
      if (dr_q) begin
        if (dr_tmr_q == PH_HALF) dr_q <= 1'b0;
        else                     dr_tmr_q <= dr_tmr_q + 1'b1;
      end
      case (state_q)
        ST_IDLE: begin
          if (rx_prev_q && !rx_i) begin
            state_q <= ST_START;
            phase_q <= '0;
          end
        end
        ST_START: begin
          if (phase_q == PH_HALF) begin
            phase_q <= '0;
            cnt_q   <= '0;
            state_q <= rx_i ? ST_IDLE : ST_DATA;
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
        ST_DATA: begin
          phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
          if (phase_q == PH_HALF) bclk_q <= 1'b0;
          if (phase_q == PH_LAST) begin
            if (cnt_q == CNT_END) begin
              if (rx_i) begin
                dr_q     <= 1'b1;
                dr_tmr_q <= '0;
                state_q  <= ST_IDLE;
              end else begin
                state_q  <= ST_BREAK;
              end
            end else begin
              bclk_q <= 1'b1;
              cnt_q  <= cnt_q + 1'b1;
            end
          end
        end
        ST_BREAK: begin
          if (rx_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bclk_o = bclk_q & ~mode_i;
  assign dr_o   = dr_q & ~mode_i;
  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/awc_bitclk_gen.sv
module awc_bitclk_gen
  import awc_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 1200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic mode_i,
  output logic data_o,
  output logic bclk_o,
  output logic dr_o
);
  localparam int DIV_RAW   = CLK_HZ / (BAUD * OSR);
  localparam int DIV       = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int PULSE_CYC = DIV * (OSR / 2);

  logic tick, rx_s, frm_idle;

  assign data_o = rx_i;

  awc_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  awc_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  awc_framer u_framer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rx_i   (rx_s),
    .mode_i (mode_i),
    .bclk_o (bclk_o),
    .dr_o   (dr_o),
    .idle_o (frm_idle)
  );
endmodule

// File: rtl/awc_bitclk_gen_chk.sv
module awc_bitclk_gen_chk #(
  parameter int PULSE_CYC = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_i,
  input logic mode_i,
  input logic bclk_o,
  input logic dr_o,
  input logic idle_i
);
  logic        bclk_d;
  logic [3:0]  rise_cnt;
  logic [31:0] bhi_len, dhi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d   <= 1'b0;
      rise_cnt <= '0;
      bhi_len  <= '0;
      dhi_len  <= '0;
    end else begin
      bclk_d  <= bclk_o;
      bhi_len <= bclk_o ? bhi_len + 1 : '0;
      dhi_len <= dr_o ? dhi_len + 1 : '0;
      if (idle_i)                rise_cnt <= '0;
      else if (bclk_o && !bclk_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  p_quiet_mode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> (!bclk_o && !dr_o));

  p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bclk_o && dr_o));

  p_eight_at_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || mode_i)
    $rose(dr_o) |-> (rise_cnt == 4'd8));

  p_no_ninth_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || mode_i)
    (bclk_o && !bclk_d) |-> (rise_cnt < 4'd8));

  p_bclk_width_r10: assert property (@(posedge clk_i) disable iff (!rst_ni || mode_i)
    $fell(bclk_o) |-> (bhi_len == 32'(PULSE_CYC)));

  p_dr_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || mode_i)
    $fell(dr_o) |-> (dhi_len == 32'(PULSE_CYC)));

  p_line_high_at_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dr_o) |-> rx_i);
endmodule

bind awc_bitclk_gen awc_bitclk_gen_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rx_i   (rx_i),
  .mode_i (mode_i),
  .bclk_o (bclk_o),
  .dr_o   (dr_o),
  .idle_i (frm_idle)
);

// File: tb/awc_bitclk_gen_tb.sv
`timescale 1ns/1ps
module awc_bitclk_gen_tb;
  localparam int CLK_HZ = 76_800;
  localparam int BAUD   = 1200;
  localparam int DIV    = CLK_HZ / (BAUD * 16);
  localparam int BIT    = DIV * 16;
  localparam int PULSE  = DIV * 8;
  localparam int SEG_IDLE = 0, SEG_START = 1, SEG_DATA = 2, SEG_STOP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic mode = 1'b0;
  logic data_o, bclk_o, dr_o;

  int checks = 0;
  int errors = 0;
  int seg = SEG_IDLE;
  int rises = 0;
  int drs = 0;
  int bhi = 0;
  int dhi = 0;
  logic bclk_prev = 1'b0;
  logic dr_prev = 1'b0;
  logic [7:0] shreg = '0;
  logic [7:0] got_bytes [0:255];
  bit finished = 0;

  always #5 clk = ~clk;

  awc_bitclk_gen #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rx_i   (rx),
    .mode_i (mode),
    .data_o (data_o),
    .bclk_o (bclk_o),
    .dr_o   (dr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] next_byte();
    return 8'($urandom);
  endfunction

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (bclk_o && !bclk_prev) begin
        rises++;
        shreg = {data_o, shreg[7:1]};
        chk(seg == SEG_DATA, "R4", seg, SEG_DATA);
      end
      if (bclk_o) bhi++;
      else if (bclk_prev) begin
        chk(bhi == PULSE, "R10", bhi, PULSE);
        bhi = 0;
      end
      if (dr_o && !dr_prev) begin
        got_bytes[drs[7:0]] = shreg;
        drs++;
        chk(seg == SEG_STOP, "R5", seg, SEG_STOP);
      end
      if (dr_o) dhi++;
      else if (dr_prev) begin
        chk(dhi == PULSE, "R6", dhi, PULSE);
        dhi = 0;
      end
      bclk_prev = bclk_o;
      dr_prev   = dr_o;
    end
  end

  task automatic drive_bit(input logic v, input int s, input int cycles);
    rx <= v;
    seg = s;
    @(negedge clk);
    chk(data_o === rx, "R1", int'(data_o), int'(rx));
    repeat (cycles - 1) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_v, input int gap_bits);
    drive_bit(1'b0, SEG_START, BIT);
    for (int i = 0; i < 8; i++) drive_bit(b[i], SEG_DATA, BIT);
    drive_bit(stop_v, SEG_STOP, BIT);
    for (int g = 0; g < gap_bits; g++) drive_bit(1'b1, SEG_IDLE, BIT);
  endtask

  task automatic frame_check(input logic [7:0] b, input logic stop_v, input bit en, input string tag);
    int r0, d0;
    r0 = rises;
    d0 = drs;
    send_frame(b, stop_v, 2);
    @(negedge clk);
    if (!en) begin
      chk(rises == r0, "R9", rises - r0, 0);
      chk(drs == d0, "R9", drs - d0, 0);
    end else begin
      chk(rises - r0 == 8, "R2", rises - r0, 8);
      if (stop_v) begin
        chk(drs - d0 == 1, "R5", drs - d0, 1);
        if (drs > d0) chk(got_bytes[8'(drs - 1)] == b, "R3",
                          int'(got_bytes[8'(drs - 1)]), int'(b));
      end else begin
        chk(drs == d0, "R8", drs - d0, 0);
      end
    end
    if (tag.len() == 0) ;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0, d0;
    logic [7:0] a, b;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(bclk_o == 1'b0, "R2", int'(bclk_o), 0);
    chk(dr_o == 1'b0, "R5", int'(dr_o), 0);
    chk(data_o == 1'b1, "R1", int'(data_o), 1);
    rst_n = 1'b1;
    repeat (3 * BIT) @(posedge clk);

    // directed patterns, R2 R3
    frame_check(8'h00, 1'b1, 1, "zeros");
    frame_check(8'hFF, 1'b1, 1, "ones");
    frame_check(8'hA5, 1'b1, 1, "alt");
    frame_check(8'h01, 1'b1, 1, "lsb");
    frame_check(8'h80, 1'b1, 1, "msb");

    // R7: short low glitch
    r0 = rises; d0 = drs;
    drive_bit(1'b0, SEG_IDLE, 3 * DIV);
    drive_bit(1'b1, SEG_IDLE, 3 * BIT);
    chk(rises == r0, "R7", rises - r0, 0);
    chk(drs == d0, "R7", drs - d0, 0);
    frame_check(8'h3C, 1'b1, 1, "after_glitch");

    // R8: low stop bit, then recovery
    frame_check(8'h5A, 1'b0, 1, "break");
    frame_check(8'hC3, 1'b1, 1, "recover");

    // R6: back-to-back words without idle gap
    r0 = rises; d0 = drs;
    a = 8'h96; b = 8'h69;
    send_frame(a, 1'b1, 0);
    send_frame(b, 1'b1, 2);
    chk(rises - r0 == 16, "R6", rises - r0, 16);
    chk(drs - d0 == 2, "R6", drs - d0, 2);
    if (drs - d0 == 2) begin
      chk(got_bytes[8'(drs - 2)] == a, "R6", int'(got_bytes[8'(drs - 2)]), int'(a));
      chk(got_bytes[8'(drs - 1)] == b, "R6", int'(got_bytes[8'(drs - 1)]), int'(b));
    end

    // R9: mode high suppresses outputs, pass-through continues
    mode = 1'b1;
    frame_check(8'hE7, 1'b1, 0, "mode_hi");
    @(negedge clk);
    chk(bclk_o == 1'b0 && dr_o == 1'b0, "R9", int'(bclk_o | dr_o), 0);
    mode = 1'b0;
    repeat (BIT) @(posedge clk);
    frame_check(8'h42, 1'b1, 1, "mode_back");

    // constrained random words, occasional bad stop bit
    for (int k = 0; k < 24; k++) begin
      logic [7:0] v;
      logic sv;
      v  = next_byte();
      sv = ($urandom_range(0, 5) != 0);
      frame_check(v, sv, 1, "rand");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule